// File: doc/BRIEF.md
# SPI Memory Command and Write-Protect Controller

This block holds the instruction decoder, status register and write gating of a small serial memory that is reached over SPI mode 0. The host frames each transaction with an active-low chip select and shifts in an 8-bit opcode, then an address byte where one is needed, then data. The SPI pins are sampled in the block's own clock domain, so the serial clock must run well below the system clock. The storage is a register file inside the block.

Writes pass three gates. The first is a write enable latch, which only one opcode can set and which many events clear. The second is a two-bit protection field that fences off the top quarter, the top half or all of the array. The third is an active-low write-protect pin that locks the protection field. An accepted write starts a timed internal cycle when chip select rises. During that cycle the busy flag is set and only the status read is honoured.

Top module: `spi_mem_ctrl`

## Requirements
- R1: The status byte reads {1111, P1, P0, WEL, BUSY}, where bit 1 is the write enable latch and bit 0 the busy flag. After reset it reads 0xF0.
- R2: Opcode 0x06 sets the write enable latch and is the only way to set it. Opcode 0x04 clears it.
- R3: While the latch is 0, a data write (0x02, address, data) and a status write (0x01, data) change neither the array nor the protection field, and neither starts a cycle.
- R4: An accepted write starts a cycle when chip select rises. The busy bit reads 1 for WR_CYCLES clocks. At the end of the cycle the data is in the array and the latch reads 0.
- R5: While the busy bit is 1, every opcode except 0x05 is ignored: 0x06 leaves the latch at 0, and a read 0x03 returns 0x00 bytes.
- R6: An accepted status write takes P1 and P0 from data bits 3 and 2. The new field is applied at the end of its cycle, which also clears the latch.
- R7: A field value of 01 protects addresses 0xC0 and up, 10 protects 0x80 and up, and 11 protects every address. A data write to a protected address is dropped: no cycle starts and the latch stays 1.
- R8: While the write-protect pin is low, a status write changes nothing and starts no cycle. A falling edge on the pin clears the latch.
- R9: A high level on the supply-drop input clears the latch.
- R10: After 0x05, each following byte in the same frame carries the current status byte, taken at that byte boundary and sent MSB first.
- R11: A read 0x03 followed by an address byte returns the data at that address, then the data at each following address, MSB first.
- R12: The data output is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| sck_i | input | 1 | SPI serial clock, mode 0 |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| wp_ni | input | 1 | Write-protect pin, active low |
| brownout_i | input | 1 | Supply-drop indication, active high |

## Verification
The bench polls the status byte across the end of a write cycle within one frame. A design that cleared the latch too early, or never, would show the wrong WEL bit beside BUSY. It then issues a latch set and a read while the cycle is still running: a decoder that did not gate on busy would set the latch or stream out array data. Each protection range is probed just inside and just outside its edge, so an off-by-one in the range compare shows up as a wrongly kept or lost byte. Finally it drops the protect pin and the supply-drop input. A design that treated the pin as a level, or wrote the field regardless of the pin, would report a field or latch value different from the model.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_RDSR, ST_READ, ST_WDATA, ST_SDATA, ST_SKIP
  } fr_state_e;
endpackage

// File: rtl/spi_mem_link.sv
module spi_mem_link (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  output logic       byte_done_o,
  output logic [7:0] byte_o,
  output logic       cs_rise_o,
  output logic       miso_o
);
  logic       sck_q, cs_q;
  logic [2:0] bit_cnt;
  logic [6:0] sh_in;
  logic [7:0] sh_out;
  logic       sck_rise, sck_fall;

  assign sck_rise    = sck_i & ~sck_q & ~cs_ni;
  assign sck_fall    = ~sck_i & sck_q & ~cs_ni;
  assign byte_done_o = sck_rise && (bit_cnt == 3'd7);
  assign byte_o      = {sh_in, mosi_i};
  assign cs_rise_o   = cs_ni & ~cs_q;
  assign miso_o      = ~cs_ni & sh_out[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= '0;
      sh_in   <= '0;
      sh_out  <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni) begin
        bit_cnt <= '0;
        sh_out  <= '0;
      end else begin
        if (sck_rise) begin
          sh_in   <= {sh_in[5:0], mosi_i};
          bit_cnt <= bit_cnt + 3'd1;
        end
        // first bit of a loaded byte must survive the falling edge after the boundary
        if (load_i) sh_out <= load_byte_i;
        else if (sck_fall && bit_cnt != 3'd0) sh_out <= {sh_out[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_mem_timer.sv
module spi_mem_timer #(
  parameter int WR_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt;

  assign busy_o = (cnt != '0);
  assign done_o = (cnt == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt <= '0;
    else if (start_i)  cnt <= CW'(WR_CYCLES);
    else if (busy_o)   cnt <= cnt - CW'(1);
  end

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i); // R5
endmodule

// File: rtl/spi_mem_status.sv
module spi_mem_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       wp_ni,
  input  logic       brownout_i,
  input  logic       done_i,
  input  logic       commit_bp_i,
  input  logic [1:0] bp_new_i,
  output logic       wel_o,
  output logic [1:0] bp_o
);
  logic wp_q, wel_q, wel_clr;
  logic [1:0] bp_q;

  assign wel_clr = clr_wel_i | brownout_i | (wp_q & ~wp_ni) | done_i;
  assign wel_o   = wel_q;
  assign bp_o    = bp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= 1'b1;
      wel_q <= 1'b0;
      bp_q  <= 2'b00;
    end else begin
      wp_q <= wp_ni;
      if (wel_clr)        wel_q <= 1'b0;
      else if (set_wel_i) wel_q <= 1'b1;
      if (commit_bp_i)    bp_q  <= bp_new_i;
    end
  end

  AST_WEL_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(set_wel_i)); // R2
  AST_WEL_WP_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wp_ni) |=> !wel_q); // R8
  AST_WEL_BROWNOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brownout_i |=> !wel_q); // R9
  AST_WEL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !wel_q); // R4
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  assign rdata_o = mem[raddr_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem[g] <= '0;
      else if (we_i && waddr_i == ADDR_W'(g))       mem[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o,
  input  logic wp_ni,
  input  logic brownout_i
);
  localparam int QTR_HI = ADDR_W - 2;

  logic              byte_done, cs_rise, load;
  logic [7:0]        rx_byte, load_byte, status, rdata;
  logic              busy, done, start, mem_we, commit_bp;
  logic              wel, set_wel, clr_wel;
  logic [1:0]        bp;
  fr_state_e         st_q, st_d;
  logic              rd_q, rd_d, wr_arm_q, wr_arm_d, sr_arm_q, sr_arm_d;
  logic [ADDR_W-1:0] addr_q, addr_d, raddr, cyc_addr_q;
  logic [7:0]        wdata_q, wdata_d, cyc_data_q;
  logic [1:0]        bpn_q, bpn_d, cyc_bp_q;
  logic              cyc_sr_q;

  function automatic logic in_prot(input logic [1:0] b, input logic [ADDR_W-1:0] a);
    unique case (b)
      2'b01:   in_prot = &a[ADDR_W-1:QTR_HI];
      2'b10:   in_prot = a[ADDR_W-1];
      2'b11:   in_prot = 1'b1;
      default: in_prot = 1'b0;
    endcase
  endfunction

  assign status = {4'hF, bp, wel, busy};

  spi_mem_link u_link (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .load_i(load), .load_byte_i(load_byte),
    .byte_done_o(byte_done), .byte_o(rx_byte),
    .cs_rise_o(cs_rise), .miso_o(miso_o)
  );

  spi_mem_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .done_o(done)
  );

  spi_mem_status u_status (
    .clk_i, .rst_ni, .set_wel_i(set_wel), .clr_wel_i(clr_wel),
    .wp_ni, .brownout_i, .done_i(done), .commit_bp_i(commit_bp),
    .bp_new_i(cyc_bp_q), .wel_o(wel), .bp_o(bp)
  );

  spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(cyc_addr_q),
    .wdata_i(cyc_data_q), .raddr_i(raddr), .rdata_o(rdata)
  );

  always_comb begin
    st_d      = st_q;
    rd_d      = rd_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    bpn_d     = bpn_q;
    wr_arm_d  = wr_arm_q;
    sr_arm_d  = sr_arm_q;
    load      = 1'b0;
    load_byte = '0;
    set_wel   = 1'b0;
    clr_wel   = 1'b0;
    raddr     = (st_q == ST_ADDR) ? rx_byte[ADDR_W-1:0] : addr_q + ADDR_W'(1);
    if (byte_done) begin
      unique case (st_q)
        ST_OPC: begin
          st_d = ST_SKIP;
          if (rx_byte == OP_RDSR) begin
            load = 1'b1; load_byte = status; st_d = ST_RDSR;
          end else if (!busy) begin
            unique case (rx_byte)
              OP_WREN:  set_wel = 1'b1;
              OP_WRDI:  clr_wel = 1'b1;
              OP_WRSR:  if (wel) st_d = ST_SDATA;
              OP_READ:  begin st_d = ST_ADDR; rd_d = 1'b1; end
              OP_WRITE: if (wel) begin st_d = ST_ADDR; rd_d = 1'b0; end
              default:  ;
            endcase
          end
        end
        ST_ADDR: begin
          addr_d = rx_byte[ADDR_W-1:0];
          if (rd_q) begin
            load = 1'b1; load_byte = rdata; st_d = ST_READ;
          end else begin
            st_d = ST_WDATA;
          end
        end
        ST_READ: begin
          addr_d = raddr; load = 1'b1; load_byte = rdata;
        end
        ST_RDSR: begin
          load = 1'b1; load_byte = status;
        end
        ST_WDATA: begin
          wdata_d = rx_byte; wr_arm_d = 1'b1; st_d = ST_SKIP;
        end
        ST_SDATA: begin
          bpn_d = rx_byte[3:2]; sr_arm_d = 1'b1; st_d = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  // cycle launch on chip-select rise; protect field and pin checked here
  assign start = cs_rise & ~busy & wel &
                 ((wr_arm_q & ~in_prot(bp, addr_q)) | (sr_arm_q & wp_ni));
  assign mem_we    = done & ~cyc_sr_q;
  assign commit_bp = done & cyc_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OPC;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      bpn_q    <= '0;
      wr_arm_q <= 1'b0;
      sr_arm_q <= 1'b0;
    end else if (cs_ni) begin
      st_q     <= ST_OPC;
      wr_arm_q <= 1'b0;
      sr_arm_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rd_q     <= rd_d;
      addr_q   <= addr_d;
      wdata_q  <= wdata_d;
      bpn_q    <= bpn_d;
      wr_arm_q <= wr_arm_d;
      sr_arm_q <= sr_arm_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_sr_q   <= 1'b0;
      cyc_addr_q <= '0;
      cyc_data_q <= '0;
      cyc_bp_q   <= '0;
    end else if (start) begin
      cyc_sr_q   <= sr_arm_q;
      cyc_addr_q <= addr_q;
      cyc_data_q <= wdata_q;
      cyc_bp_q   <= bpn_q;
    end
  end

  AST_CYCLE_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel)); // R3
  AST_NO_PROT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !in_prot(bp, cyc_addr_q)); // R7
endmodule

// File: tb/spi_mem_ctrl_bench.sv
module spi_mem_ctrl_bench;
  localparam int WR = 400;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1, bo = 1'b0;
  logic miso;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_mem_ctrl #(.ADDR_W(8), .WR_CYCLES(WR)) u_spi_mem_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .wp_ni(wp_n), .brownout_i(bo)
  );

  // reference model
  logic [7:0] mm [256];
  logic       m_wel = 1'b0;
  logic [1:0] m_bp = 2'b00;
  int         busy_end = -100000, busy_start = -100000;
  int         pend = 0;
  logic [7:0] p_addr, p_data;
  logic [1:0] p_bp;

  logic [7:0] tx [16];
  logic [7:0] rx [16];
  int         ld [16];

  function automatic bit m_prot(input logic [1:0] b, input logic [7:0] a);
    return (b == 2'd3) || (b == 2'd2 && a >= 8'h80) || (b == 2'd1 && a >= 8'hC0);
  endfunction

  function automatic void sync(input int at);
    if (pend != 0 && at >= busy_end) begin
      if (pend == 1) mm[p_addr] = p_data;
      else           m_bp = p_bp;
      m_wel = 1'b0;
      pend = 0;
    end
  endfunction

  function automatic logic [7:0] m_status(input int at);
    sync(at);
    return {4'hF, m_bp, m_wel, (at > busy_start && at < busy_end)};
  endfunction

  function automatic bit near_end(input int at);
    return (at > busy_end - 4) && (at < busy_end + 4);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp,
                     input logic [7:0] mask);
    n_chk++;
    if ((act & mask) !== (exp & mask)) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h (mask %02h)", req, act, exp, mask);
    end
  endtask

  // R12: output idle while deselected, checked every clock
  always @(posedge clk) begin
    #1;
    if (rst_ni && cs_n) begin
      n_chk++;
      if (miso !== 1'b0) begin
        n_fail++;
        $display("FAIL R12: actual %b expected 0", miso);
      end
    end
  end

  task automatic frame(input int n, input string req);
    int rise;
    bit op_busy;
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        mosi = tx[k][7-b];
        repeat (3) @(negedge clk);
        rx[k][7-b] = miso;
        sck = 1'b1;
        if (b == 7) ld[k] = cyc + 1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
      end
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    rise = cyc;
    op_busy = (ld[0] > busy_start && ld[0] < busy_end);
    if (tx[0] == 8'h05) begin
      for (int k = 1; k < n; k++)
        chk(req, rx[k], m_status(ld[k-1]), near_end(ld[k-1]) ? 8'hF0 : 8'hFF);
    end else if (tx[0] == 8'h03) begin
      sync(ld[0]);
      for (int k = 2; k < n; k++)
        chk(req, rx[k], op_busy ? 8'h00 : mm[8'(tx[1] + 8'(k - 2))], 8'hFF);
    end
    sync(rise);
    if (!op_busy) begin
      case (tx[0])
        8'h06: m_wel = 1'b1;
        8'h04: m_wel = 1'b0;
        8'h01: if (m_wel && n >= 2 && wp_n) begin
          pend = 2; p_bp = tx[1][3:2];
          busy_start = rise + 1; busy_end = rise + WR + 1;
        end
        8'h02: if (m_wel && n >= 3 && !m_prot(m_bp, tx[1])) begin
          pend = 1; p_addr = tx[1]; p_data = tx[2];
          busy_start = rise + 1; busy_end = rise + WR + 1;
        end
        default: ;
      endcase
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op, input string req);
    tx[0] = op; frame(1, req);
  endtask
  task automatic rdsr(input int nb, input string req);
    tx[0] = 8'h05; frame(nb + 1, req);
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
    tx[0] = 8'h02; tx[1] = a; tx[2] = d; frame(3, req);
  endtask
  task automatic wrsr(input logic [7:0] d, input string req);
    tx[0] = 8'h01; tx[1] = d; frame(2, req);
  endtask
  task automatic rd(input logic [7:0] a, input int nb, input string req);
    tx[0] = 8'h03; tx[1] = a;
    for (int k = 0; k < nb; k++) tx[k+2] = 8'h00;
    frame(nb + 2, req);
  endtask
  task automatic settle();
    repeat (WR + 20) @(negedge clk);
    sync(cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = 8'h00;
    for (int k = 0; k < 16; k++) tx[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    rdsr(2, "R1 R10 reset status");

    wr(8'h10, 8'hA5, "R3 write without latch");
    wrsr(8'h0C, "R3 status write without latch");
    rd(8'h10, 1, "R3 array unchanged");
    rdsr(1, "R3 status unchanged");

    op1(8'h06, "R2 set latch");
    rdsr(1, "R2 latch set");
    op1(8'h04, "R2 clear latch");
    rdsr(1, "R2 latch cleared");

    op1(8'h06, "R4 set latch");
    wr(8'h10, 8'hA5, "R4 write");
    rdsr(10, "R4 R10 busy polling");
    settle();
    rd(8'h10, 1, "R4 data stored");

    op1(8'h06, "R5 set latch");
    wr(8'h11, 8'h5A, "R5 write");
    op1(8'h06, "R5 set latch while busy");
    rd(8'h10, 2, "R5 read while busy");
    settle();
    rdsr(1, "R5 latch still clear");

    rd(8'h10, 3, "R11 sequential read");
    rd(8'hFF, 2, "R11 address wrap");

    op1(8'h06, "R6 set latch");
    wrsr(8'h04, "R6 field 01");
    rdsr(1, "R6 pending");
    settle();
    rdsr(1, "R6 field applied");

    op1(8'h06, "R7 set latch");
    wr(8'hC0, 8'h11, "R7 quarter blocked");
    rdsr(1, "R7 no cycle, latch kept");
    wr(8'hBF, 8'h77, "R7 below quarter");
    settle();
    rd(8'hBF, 2, "R7 quarter edge");

    op1(8'h06, "R6 set latch");
    wrsr(8'h08, "R6 field 10");
    settle();
    op1(8'h06, "R7 set latch");
    wr(8'h80, 8'h22, "R7 half blocked");
    wr(8'h7F, 8'h33, "R7 below half");
    settle();
    rd(8'h7F, 2, "R7 half edge");

    op1(8'h06, "R6 set latch");
    wrsr(8'h0C, "R6 field 11");
    settle();
    op1(8'h06, "R7 set latch");
    wr(8'h10, 8'hFF, "R7 all blocked");
    rdsr(1, "R7 latch kept");
    rd(8'h10, 1, "R7 low address kept");

    @(negedge clk); wp_n = 1'b0; m_wel = 1'b0;
    repeat (3) @(negedge clk);
    rdsr(1, "R8 pin fall clears latch");
    op1(8'h06, "R8 set latch under pin");
    wrsr(8'h00, "R8 status write under pin");
    rdsr(1, "R8 field locked");
    repeat (WR + 20) @(negedge clk);
    rdsr(1, "R8 no cycle ran");
    @(negedge clk); wp_n = 1'b1;
    repeat (3) @(negedge clk);
    rdsr(1, "R8 pin rise keeps latch");

    @(negedge clk); bo = 1'b1;
    @(negedge clk); bo = 1'b0; m_wel = 1'b0;
    repeat (2) @(negedge clk);
    rdsr(1, "R9 supply drop clears latch");

    op1(8'h06, "R6 set latch");
    wrsr(8'h00, "R6 clear field");
    settle();
    rdsr(2, "R6 R10 field cleared");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule